// File: doc/BRIEF.md
# Twin-Predicate Restart Index Recovery

With twin predication the source and destination element positions advance independently, each under its own predicate mask. After an exception or a context switch only one restart index is kept. This block takes that index and the two masks and derives the matching position in the other element stream. It counts the set bits of the source mask that lie below the restart index, giving k. It then looks for the (k+1)-th set bit of the destination mask and reports that bit's position.

The engine is bit-serial. Two shift registers feed one mask bit each per cycle into two counters: a set-bit tally and a position counter. This trades a wide bit-gather/bit-scatter network for a result that takes up to about 130 cycles. That is acceptable because restart writes are rare. `busy` stays high for the whole computation so that execution units downstream can be stalled.

The controller has four states:
- `ST_IDLE` waits for a start.
- `ST_COUNT` walks the source mask below the restart index.
- `ST_SEEK` walks the destination mask.
- `ST_DONE` raises the done pulse.

Transitions:
- A start pulse goes from any state to `ST_COUNT`, or straight to `ST_SEEK` when the restart index is zero.
- `ST_COUNT` goes to `ST_SEEK` once the last position below the index has been tallied.
- `ST_SEEK` goes to `ST_DONE` on the wanted set bit, or after position MASK_W-1.
- `ST_DONE` returns to `ST_IDLE`.

Top module: `trp_restart_recover`

## Requirements
- R1: After reset `busy`, `done`, `valid` and `exhausted` are 0 and `other_idx` is 0.
- R2: A cycle with `start` high captures both masks and `restart_idx`. `busy` is high from the next cycle up to and including the cycle in which `done` is high. `done` is high for exactly one cycle.
- R3: The tally k equals the number of set bits of `src_mask` at positions strictly below `restart_idx`. Bits at or above the index do not count.
- R4: When `dst_mask` has more than k set bits, `other_idx` at `done` is the position of its (k+1)-th set bit, counting from bit 0, and `exhausted` is 0.
- R5: When `dst_mask` has k or fewer set bits, `other_idx` at `done` equals MASK_W (64) and `exhausted` is 1.
- R6: A `restart_idx` of 0 skips the source walk. The result is the position of the lowest set bit of `dst_mask`.
- R7: Let r be `restart_idx` and s be j+1 on a hit at position j, or MASK_W on a miss. `done` is high in the cycle that follows the r+s-th rising edge after the edge that samples `start`.
- R8: `start` while `busy` abandons the computation in progress. The next result depends only on the inputs captured by the new start.
- R9: `valid` is 0 in the cycle after a start and 1 from the cycle after `done` until the next start. `other_idx` and `exhausted` hold their values while `valid` is 1.
- R10: Changes on `src_mask`, `dst_mask` and `restart_idx` while `busy` is high have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Restart index written; begin a fresh computation |
| restart_idx | input | 6 | Visible restart index into the source stream |
| src_mask | input | 64 | Source predicate mask |
| dst_mask | input | 64 | Destination predicate mask |
| busy | output | 1 | Computation in progress; stall dependent units |
| done | output | 1 | One-cycle pulse when the result is ready |
| valid | output | 1 | Held result is current |
| other_idx | output | 7 | Recovered destination index, or 64 when exhausted |
| exhausted | output | 1 | Destination mask ran out of set bits |

## Verification
The hardest case to reach is a start that lands while a long computation is part-way through its source walk. Without care, the abandoned tally or position would leak into the new result. The bench issues a start with a large index and masks that give a distinct answer. It waits a fixed number of cycles and then restarts with different masks, so any residue shows as a wrong index. Every restart index from 0 to 63 is also swept against fixed and pseudo-random mask pairs. Some of these runs scramble the inputs while busy, which exposes any path that reads a mask after capture.

// File: rtl/trp_pkg.sv
package trp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_SEEK  = 2'd2,
        ST_DONE  = 2'd3
    } trp_state_e;
endpackage

// File: rtl/trp_shreg.sv
module trp_shreg #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic         lsb
);
    logic [W-1:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= din;
        end else if (shift) begin
            q <= {1'b0, q[W-1:1]};
        end
    end

    assign lsb = q[0];
endmodule

// File: rtl/trp_counter.sv
module trp_counter #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] value
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else if (clr) begin
            value <= '0;
        end else if (inc && !dec) begin
            value <= value + W'(1);
        end else if (dec && !inc) begin
            value <= value - W'(1);
        end
    end
endmodule

// File: rtl/trp_fsm.sv
module trp_fsm
    import trp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic idx_zero,
    input  logic cnt_last,
    input  logic seek_last,
    input  logic src_bit,
    input  logic dst_bit,
    input  logic k_zero,
    output logic load,
    output logic shift_src,
    output logic shift_dst,
    output logic pos_clr,
    output logic pos_inc,
    output logic k_clr,
    output logic k_inc,
    output logic k_dec,
    output logic hit,
    output logic miss,
    output logic busy,
    output logic done
);
    trp_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = idx_zero ? ST_SEEK : ST_COUNT;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_COUNT: if (cnt_last) state_d = ST_SEEK;
                ST_SEEK:  if ((dst_bit && k_zero) || seek_last) state_d = ST_DONE;
                ST_DONE:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        load      = 1'b0;
        shift_src = 1'b0;
        shift_dst = 1'b0;
        pos_clr   = 1'b0;
        pos_inc   = 1'b0;
        k_clr     = 1'b0;
        k_inc     = 1'b0;
        k_dec     = 1'b0;
        hit       = 1'b0;
        miss      = 1'b0;
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_DONE);
        if (start) begin
            load    = 1'b1;
            pos_clr = 1'b1;
            k_clr   = 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_COUNT: begin
                    shift_src = 1'b1;
                    k_inc     = src_bit;
                    pos_clr   = cnt_last;
                    pos_inc   = !cnt_last;
                end
                ST_SEEK: begin
                    shift_dst = 1'b1;
                    pos_inc   = 1'b1;
                    if (dst_bit && k_zero) begin
                        hit = 1'b1;
                    end else begin
                        k_dec = dst_bit;
                        miss  = seek_last;
                    end
                end
                ST_DONE: ;
            endcase
        end
    end
endmodule

// File: rtl/trp_restart_recover.sv
module trp_restart_recover #(
    parameter int MASK_W = 64,
    localparam int IDX_W = $clog2(MASK_W),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IDX_W-1:0]  restart_idx,
    input  logic [MASK_W-1:0] src_mask,
    input  logic [MASK_W-1:0] dst_mask,
    output logic              busy,
    output logic              done,
    output logic              valid,
    output logic [CNT_W-1:0]  other_idx,
    output logic              exhausted
);
    logic             load, shift_src, shift_dst;
    logic             pos_clr, pos_inc, k_clr, k_inc, k_dec;
    logic             hit, miss;
    logic             src_bit, dst_bit;
    logic [CNT_W-1:0] pos_q, k_q;
    logic [IDX_W-1:0] limit_q;
    logic             cnt_last, seek_last, k_zero, idx_zero;

    trp_shreg #(.W(MASK_W)) u_src_sh (
        .clk(clk), .rst_n(rst_n), .load(load), .shift(shift_src),
        .din(src_mask), .lsb(src_bit)
    );

    trp_shreg #(.W(MASK_W)) u_dst_sh (
        .clk(clk), .rst_n(rst_n), .load(load), .shift(shift_dst),
        .din(dst_mask), .lsb(dst_bit)
    );

    trp_counter #(.W(CNT_W)) u_pos_cnt (
        .clk(clk), .rst_n(rst_n), .clr(pos_clr), .inc(pos_inc),
        .dec(1'b0), .value(pos_q)
    );

    trp_counter #(.W(CNT_W)) u_k_cnt (
        .clk(clk), .rst_n(rst_n), .clr(k_clr), .inc(k_inc),
        .dec(k_dec), .value(k_q)
    );

    assign idx_zero  = (restart_idx == '0);
    assign cnt_last  = ({1'b0, limit_q} == (pos_q + CNT_W'(1)));
    assign seek_last = (pos_q == CNT_W'(MASK_W - 1));
    assign k_zero    = (k_q == '0);

    trp_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .idx_zero(idx_zero),
        .cnt_last(cnt_last), .seek_last(seek_last), .src_bit(src_bit),
        .dst_bit(dst_bit), .k_zero(k_zero), .load(load),
        .shift_src(shift_src), .shift_dst(shift_dst), .pos_clr(pos_clr),
        .pos_inc(pos_inc), .k_clr(k_clr), .k_inc(k_inc), .k_dec(k_dec),
        .hit(hit), .miss(miss), .busy(busy), .done(done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            limit_q   <= '0;
            other_idx <= '0;
            exhausted <= 1'b0;
            valid     <= 1'b0;
        end else if (start) begin
            limit_q <= restart_idx;
            valid   <= 1'b0;
        end else begin
            if (hit) begin
                other_idx <= pos_q;
                exhausted <= 1'b0;
            end
            if (miss) begin
                other_idx <= CNT_W'(MASK_W);
                exhausted <= 1'b1;
            end
            if (done) begin
                valid <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/trp_restart_recover_chk.sv
module trp_restart_recover_chk #(
    parameter int MASK_W = 64,
    localparam int CNT_W = $clog2(MASK_W) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             valid,
    input logic [CNT_W-1:0] other_idx,
    input logic             exhausted
);
    p_start_sets_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_busy_through_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));
    p_hit_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !exhausted) |-> (other_idx < CNT_W'(MASK_W)));
    p_exhaust_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && exhausted) |-> (other_idx == CNT_W'(MASK_W)));
    p_start_drops_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !valid);
    p_valid_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> valid);
    p_valid_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && $past(valid)) |-> ($stable(other_idx) && $stable(exhausted)));
endmodule

bind trp_restart_recover trp_restart_recover_chk #(.MASK_W(MASK_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .valid(valid), .other_idx(other_idx), .exhausted(exhausted)
);

// File: tb/trp_restart_recover_tb.sv
module trp_restart_recover_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  ridx = '0;
    logic [63:0] src = '0;
    logic [63:0] dst = '0;
    logic        busy, done, valid, exhausted;
    logic [6:0]  other_idx;
    int          n_vec = 0;
    int          n_bad = 0;
    int          cyc = 0;
    logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

    always #10 clk = ~clk;

    trp_restart_recover u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .restart_idx(ridx),
        .src_mask(src), .dst_mask(dst), .busy(busy), .done(done),
        .valid(valid), .other_idx(other_idx), .exhausted(exhausted)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 190000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < 190000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    function automatic logic [63:0] nxt(input logic [63:0] x);
        logic [63:0] y = x;
        y = y ^ (y << 13);
        y = y ^ (y >> 7);
        y = y ^ (y << 17);
        return y;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic ref_calc(input logic [63:0] s, input logic [63:0] d, input int r,
                            output int idx, output bit ex, output int lat);
        int k = 0;
        int seen = 0;
        for (int i = 0; i < r; i++) if (s[i]) k++;
        idx = 64;
        ex  = 1'b1;
        for (int j = 0; j < 64; j++) begin
            if (d[j]) begin
                if (ex && seen == k) begin
                    idx = j;
                    ex  = 1'b0;
                end
                seen++;
            end
        end
        lat = r + (ex ? 64 : idx + 1) + 1;
    endtask

    task automatic run_one(input logic [63:0] s, input logic [63:0] d, input int r,
                           input bit scr, input string tag);
        int eidx, elat, n;
        bit eex;
        ref_calc(s, d, r, eidx, eex, elat);
        @(negedge clk);
        src = s; dst = d; ridx = 6'(r); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        chk(busy === 1'b1, "R2 busy after start", busy, 1);
        chk(valid === 1'b0, "R9 valid low after start", valid, 0);
        while (done !== 1'b1 && n < 200) begin
            if (scr) begin
                rng = nxt(rng); src = rng;
                rng = nxt(rng); dst = rng; ridx = rng[5:0];
            end
            if (busy !== 1'b1) chk(1'b0, "R2 busy dropped early", busy, 1);
            @(negedge clk);
            n++;
        end
        chk(n == elat, "R7 latency", n, elat);
        chk(other_idx == 7'(eidx), tag, other_idx, eidx);
        chk(exhausted == eex, eex ? "R5 exhausted flag" : "R4 exhausted flag", exhausted, eex);
        @(negedge clk);
        chk(done === 1'b0, "R2 done one cycle", done, 0);
        chk(busy === 1'b0, "R2 busy after done", busy, 0);
        chk(valid === 1'b1 && other_idx == 7'(eidx), "R9 held result", other_idx, eidx);
    endtask

    initial begin
        logic [63:0] pats_s [6];
        logic [63:0] pats_d [6];
        pats_s[0] = '1;                    pats_d[0] = '1;
        pats_s[1] = 64'h5555_5555_5555_5555; pats_d[1] = 64'hAAAA_AAAA_AAAA_AAAA;
        pats_s[2] = '0;                    pats_d[2] = 64'h8000_0000_0000_0000;
        pats_s[3] = '1;                    pats_d[3] = 64'h0000_0000_FFFF_0000;
        pats_s[4] = 64'hF0F0_0F0F_3C3C_C3C3; pats_d[4] = '0;
        pats_s[5] = 64'h0123_4567_89AB_CDEF; pats_d[5] = 64'hFEDC_BA98_7654_3210;

        #35;
        // R1 reset state
        chk(busy === 1'b0, "R1 busy", busy, 0);
        chk(done === 1'b0, "R1 done", done, 0);
        chk(valid === 1'b0, "R1 valid", valid, 0);
        chk(exhausted === 1'b0, "R1 exhausted", exhausted, 0);
        chk(other_idx === 7'd0, "R1 other_idx", other_idx, 0);
        rst_n = 1'b1;

        // R6 restart 0: lowest set bit of dst
        run_one('1, 64'h0000_0000_0000_0100, 0, 1'b0, "R6 zero index");
        run_one('0, 64'h8000_0000_0000_0000, 0, 1'b0, "R6 top bit");
        run_one('1, '0, 0, 1'b0, "R6 empty dst");

        // R3/R4/R5 sweep of every restart index over fixed patterns
        for (int p = 0; p < 6; p++)
            for (int r = 0; r < 64; r++)
                run_one(pats_s[p], pats_d[p], r, 1'b0, "R3 R4 sweep");

        // R3: bits at or above index ignored (src above r flipped, same result)
        run_one(64'h0000_0000_0000_00FF, '1, 8, 1'b0, "R3 below only");
        run_one(64'hFFFF_FFFF_FFFF_FFFF, '1, 8, 1'b0, "R3 upper bits ignored");

        // R10 random masks with inputs scrambled while busy
        for (int t = 0; t < 150; t++) begin
            logic [63:0] a, b;
            rng = nxt(rng); a = rng;
            rng = nxt(rng); b = rng & nxt(rng);
            rng = nxt(rng);
            run_one(a, b, int'(rng[5:0]), 1'b1, "R10 scrambled");
        end

        // R8 abort: long run interrupted, second start's inputs rule
        begin
            int eidx, elat;
            bit eex;
            @(negedge clk);
            src = '1; dst = 64'h0000_0000_0000_0001; ridx = 6'd50; start = 1'b1;
            @(negedge clk); start = 1'b0;
            repeat (20) @(negedge clk);
            ref_calc(64'h0000_0000_0000_0007, 64'h0000_0000_0F00_0000, 5, eidx, eex, elat);
            src = 64'h0000_0000_0000_0007; dst = 64'h0000_0000_0F00_0000; ridx = 6'd5;
            start = 1'b1;
            @(negedge clk); start = 1'b0;
            chk(valid === 1'b0, "R8 valid low after restart", valid, 0);
            for (int w = 0; w < 200 && done !== 1'b1; w++) @(negedge clk);
            chk(other_idx == 7'(eidx), "R8 abort result", other_idx, eidx);
            chk(exhausted == eex, "R8 abort flag", exhausted, eex);
            @(negedge clk);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule